// File: doc/BRIEF.md
# Remappable Peripheral Pin Crossbar

This block connects a set of general-purpose I/O pins to peripheral functions through software-programmed select registers. Each peripheral input function owns one select register holding the index of the pin it listens to. Each pin owns one select register holding a code that names which peripheral output function drives it. Code zero leaves the pin undriven. Any mix of mappings is legal. One pin may feed several peripheral inputs, and one peripheral output may drive several pins.

Software reaches the select registers over a simple request/acknowledge register bus. An external lock input guards the registers. While the lock is high, a write is still acknowledged, but it changes nothing. Every select register has a shadow copy. Live and shadow copies are compared on every cycle. Any difference, such as a bit upset in the live storage, raises a configuration-mismatch reset request for the chip's reset logic.

Top module: `pin_xbar`

## Requirements
- R1: After reset, every select register reads zero. Every peripheral input then follows pin 0, every pin output enable is low, and the mismatch request is low.
- R2: Peripheral input i equals pin_in[s], where s is the value of input-select register i, if s < N_PINS. If s >= N_PINS, peripheral input i is constant 0.
- R3: For a pin whose output code c lies in 1..N_OUT_FN, pin_out equals periph_out[c-1] and pin_oe is 1. For c = 0, or for c > N_OUT_FN, both pin_out and pin_oe are 0.
- R4: No interlock exists between registers. Several inputs may select the same pin, and several pins may carry the same output code. Each of them routes as in R2 and R3.
- R5: A write made while cfg_lock is 1 is acknowledged but leaves every register unchanged.
- R6: bus_ack is high in exactly the cycle after each cycle with bus_req high. For a read, bus_rdata in that cycle holds the live register value, whether the lock is high or low.
- R7: mismatch_req is high in the cycle after any select register differs from its shadow copy. It stays high while the difference remains.
- R8: An accepted write updates the live register and its shadow at the same edge. Normal writes therefore never raise mismatch_req, and rewriting a corrupted register clears the request one cycle later.
- R9: Addresses 0..N_IN_FN-1 select the input-select registers. Addresses N_IN_FN..N_IN_FN+N_PINS-1 select the pin registers, in pin order. Writes to higher addresses change nothing, and reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lock | input | 1 | Blocks register writes when high |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | REG_W | Write data |
| bus_ack | output | 1 | Access acknowledge, one cycle after the request |
| bus_rdata | output | REG_W | Read data, valid with bus_ack |
| pin_in | input | N_PINS | Pin input levels |
| pin_out | output | N_PINS | Pin output levels |
| pin_oe | output | N_PINS | Pin output enables |
| periph_out | input | N_OUT_FN | Peripheral output function levels |
| periph_in | output | N_IN_FN | Peripheral input function levels |
| mismatch_req | output | 1 | Configuration-mismatch reset request |

## Verification
The routing is tried under three kinds of stimulus:
- Random register contents with random pin and peripheral levels. These catch wrong select indexing and swapped pin/function slots.
- Directed fan-in and fan-out mappings. These separate a true crossbar from one that quietly drops duplicate selections.
- Out-of-range selects and undefined codes. These expose missing range checks.

Random writes with the lock toggled at random distinguish ignored writes from accepted ones. Read-back compares the register file to the model. Forcing a single live bit tells a real shadow comparison apart from one that tracks the live copy.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
   // Bus operation as decoded at the register port.
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } xbar_op_e;

   // Number of bits needed to count to n (at least 1).
   function automatic int bits_for(input int n);
      int b;
      b = 1;
      while ((1 << b) < n) b++;
      return b;
   endfunction
endpackage

// File: rtl/xbar_sel_bank.sv
module xbar_sel_bank #(
   parameter int NREG   = 12,
   parameter int REG_W  = 4,
   parameter int ADDR_W = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_stb,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [REG_W-1:0]        wr_data,
   output logic [NREG*REG_W-1:0]   live_q,
   output logic                    mismatch_q
);
   localparam int FLAT_W = NREG * REG_W;

   logic [FLAT_W-1:0] shadow_q;
   logic [FLAT_W-1:0] wr_mask;
   logic [FLAT_W-1:0] wr_fill;

   // Expand the addressed write into a mask and replicated data.
   always_comb begin
      wr_mask = '0;
      wr_fill = '0;
      for (int r = 0; r < NREG; r++) begin
         wr_fill[r*REG_W +: REG_W] = wr_data;
         if (wr_stb && (wr_addr == ADDR_W'(r)))
            wr_mask[r*REG_W +: REG_W] = '1;
      end
   end

   // Live and shadow copies move together, only on accepted writes.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_q     <= '0;
         shadow_q   <= '0;
         mismatch_q <= 1'b0;
      end else begin
         live_q     <= (live_q & ~wr_mask) | (wr_fill & wr_mask);
         shadow_q   <= (shadow_q & ~wr_mask) | (wr_fill & wr_mask);
         mismatch_q <= (live_q != shadow_q);
      end
   end
endmodule

// File: rtl/xbar_in_route.sv
module xbar_in_route #(
   parameter int N_IN_FN = 4,
   parameter int N_PINS  = 8,
   parameter int REG_W   = 4
) (
   input  logic [N_PINS-1:0]        pin_in,
   input  logic [N_IN_FN*REG_W-1:0] sel_flat,
   output logic [N_IN_FN-1:0]       periph_in
);
   for (genvar gi = 0; gi < N_IN_FN; gi++) begin : g_in
      logic [REG_W-1:0] sel;
      assign sel = sel_flat[gi*REG_W +: REG_W];
      // Unmatched (out-of-range) selects fall through to 0.
      always_comb begin
         periph_in[gi] = 1'b0;
         for (int p = 0; p < N_PINS; p++)
            if (sel == REG_W'(p)) periph_in[gi] = pin_in[p];
      end
   end
endmodule

// File: rtl/xbar_out_route.sv
module xbar_out_route #(
   parameter int N_PINS   = 8,
   parameter int N_OUT_FN = 5,
   parameter int REG_W    = 4
) (
   input  logic [N_OUT_FN-1:0]     periph_out,
   input  logic [N_PINS*REG_W-1:0] code_flat,
   output logic [N_PINS-1:0]       pin_out,
   output logic [N_PINS-1:0]       pin_oe
);
   for (genvar gp = 0; gp < N_PINS; gp++) begin : g_pin
      logic [REG_W-1:0] code;
      assign code = code_flat[gp*REG_W +: REG_W];
      // Code 0 and undefined codes leave the pin disconnected.
      always_comb begin
         pin_out[gp] = 1'b0;
         pin_oe[gp]  = 1'b0;
         for (int f = 0; f < N_OUT_FN; f++) begin
            if (code == REG_W'(f + 1)) begin
               pin_out[gp] = periph_out[f];
               pin_oe[gp]  = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar #(
   parameter int N_PINS   = 8,
   parameter int N_IN_FN  = 4,
   parameter int N_OUT_FN = 5,
   parameter int REG_W    = 4,
   parameter int ADDR_W   = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_lock,
   input  logic                 bus_req,
   input  logic                 bus_we,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [REG_W-1:0]     bus_wdata,
   output logic                 bus_ack,
   output logic [REG_W-1:0]     bus_rdata,
   input  logic [N_PINS-1:0]    pin_in,
   output logic [N_PINS-1:0]    pin_out,
   output logic [N_PINS-1:0]    pin_oe,
   input  logic [N_OUT_FN-1:0]  periph_out,
   output logic [N_IN_FN-1:0]   periph_in,
   output logic                 mismatch_req
);
   import xbar_pkg::*;

   localparam int NREG   = N_IN_FN + N_PINS;
   localparam int FLAT_W = NREG * REG_W;
   localparam int IN_W   = N_IN_FN * REG_W;

   // Elaboration-time parameter checks.
   if (REG_W < bits_for(N_PINS))
      $error("REG_W too narrow for pin index");
   if ((1 << REG_W) <= N_OUT_FN)
      $error("REG_W too narrow for output codes");
   if ((1 << ADDR_W) < NREG)
      $error("ADDR_W too narrow for register count");

   xbar_op_e          op;
   logic              addr_ok;
   logic              wr_stb;
   logic [REG_W-1:0]  rd_mux;
   logic [FLAT_W-1:0] live_flat;

   // Full address decode needs no range compare.
   if (NREG == (1 << ADDR_W)) begin : g_full_map
      assign addr_ok = 1'b1;
   end else begin : g_part_map
      assign addr_ok = (bus_addr < ADDR_W'(NREG));
   end

   always_comb begin
      if (!bus_req)    op = OP_IDLE;
      else if (bus_we) op = OP_WRITE;
      else             op = OP_READ;
   end

   assign wr_stb = (op == OP_WRITE) && addr_ok && !cfg_lock;

   always_comb begin
      rd_mux = '0;
      for (int r = 0; r < NREG; r++)
         if (bus_addr == ADDR_W'(r)) rd_mux = live_flat[r*REG_W +: REG_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack   <= (op != OP_IDLE);
         bus_rdata <= (op == OP_READ && addr_ok) ? rd_mux : '0;
      end
   end

   xbar_sel_bank #(.NREG(NREG), .REG_W(REG_W), .ADDR_W(ADDR_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (wr_stb),
      .wr_addr    (bus_addr),
      .wr_data    (bus_wdata),
      .live_q     (live_flat),
      .mismatch_q (mismatch_req)
   );

   xbar_in_route #(.N_IN_FN(N_IN_FN), .N_PINS(N_PINS), .REG_W(REG_W)) u_in (
      .pin_in    (pin_in),
      .sel_flat  (live_flat[IN_W-1:0]),
      .periph_in (periph_in)
   );

   xbar_out_route #(.N_PINS(N_PINS), .N_OUT_FN(N_OUT_FN), .REG_W(REG_W)) u_out (
      .periph_out (periph_out),
      .code_flat  (live_flat[FLAT_W-1:IN_W]),
      .pin_out    (pin_out),
      .pin_oe     (pin_oe)
   );
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk #(
   parameter int N_PINS = 8,
   parameter int FLAT_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_lock,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_ack,
   input logic [N_PINS-1:0] pin_out,
   input logic [N_PINS-1:0] pin_oe,
   input logic [FLAT_W-1:0] live_flat
);
   AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |=> bus_ack); // R6
   AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_req |=> !bus_ack); // R6
   AST_UNDRIVEN_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0); // R3
   AST_LOCKED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_lock && bus_req && bus_we) |=> $stable(live_flat)); // R5
endmodule

bind pin_xbar xbar_chk #(.N_PINS(N_PINS), .FLAT_W(FLAT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_lock  (cfg_lock),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_ack   (bus_ack),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .live_flat (live_flat)
);

// File: tb/test_pin_xbar.sv
module test_pin_xbar;
   localparam int NP = 8, NI = 4, NO = 5, RW = 4, AW = 4;
   localparam int NR = NI + NP;

   logic clk = 1'b0, rst_n = 1'b0, cfg_lock = 1'b0;
   logic bus_req = 1'b0, bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [RW-1:0] bus_wdata = '0;
   logic bus_ack, mismatch_req;
   logic [RW-1:0] bus_rdata;
   logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
   logic [NO-1:0] periph_out = '0;
   logic [NI-1:0] periph_in;

   int n_chk = 0, n_err = 0;
   logic [RW-1:0] model [NR];

   always #4 clk = ~clk;

   pin_xbar #(.N_PINS(NP), .N_IN_FN(NI), .N_OUT_FN(NO), .REG_W(RW), .ADDR_W(AW)) i_pin_xbar (
      .clk(clk), .rst_n(rst_n), .cfg_lock(cfg_lock), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .periph_out(periph_out),
      .periph_in(periph_in), .mismatch_req(mismatch_req));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [NI-1:0] exp_pin_to_fn();
      logic [NI-1:0] v;
      for (int i = 0; i < NI; i++)
         v[i] = (int'(model[i]) < NP) ? pin_in[model[i]] : 1'b0;
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_oe();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) begin
         int c = int'(model[NI+p]);
         v[p] = (c >= 1 && c <= NO);
      end
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_pout();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) begin
         int c = int'(model[NI+p]);
         v[p] = (c >= 1 && c <= NO) ? periph_out[c-1] : 1'b0;
      end
      return v;
   endfunction

   function automatic logic [NR*RW-1:0] packed_model();
      logic [NR*RW-1:0] v;
      for (int r = 0; r < NR; r++) v[r*RW +: RW] = model[r];
      return v;
   endfunction

   task automatic bus_write(input int a, input logic [RW-1:0] d, input string req);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      if (!cfg_lock && a < NR) model[a] = d;
      @(negedge clk);
      chk(bus_ack === 1'b1, req, 32'(bus_ack), 1);
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input int a, input string req);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
      @(negedge clk);
      chk(bus_ack === 1'b1, "R6 read ack", 32'(bus_ack), 1);
      chk(bus_rdata === ((a < NR) ? model[a] : '0), req, 32'(bus_rdata),
          32'((a < NR) ? model[a] : '0));
      bus_req = 1'b0;
   endtask

   task automatic check_routes(input string req);
      #1;
      chk(periph_in === exp_pin_to_fn(), {req, " periph_in"}, 32'(periph_in), 32'(exp_pin_to_fn()));
      chk(pin_oe === exp_oe(), {req, " pin_oe"}, 32'(pin_oe), 32'(exp_oe()));
      chk(pin_out === exp_pout(), {req, " pin_out"}, 32'(pin_out), 32'(exp_pout()));
   endtask

   initial begin
      #(8 * 200000);
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      for (int r = 0; r < NR; r++) model[r] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      pin_in = 8'h01; periph_out = '1; #1;
      chk(periph_in === 4'hF, "R1 inputs follow pin0", 32'(periph_in), 32'hF);
      chk(pin_oe === '0, "R1 no pin driven", 32'(pin_oe), 0);
      chk(mismatch_req === 1'b0, "R1 no mismatch", 32'(mismatch_req), 0);
      pin_in = 8'hFE; #1;
      chk(periph_in === 4'h0, "R1 pin0 low", 32'(periph_in), 0);
      for (int r = 0; r < NR; r++) bus_read(r, "R1 register zero");

      // R4 fan-in: all inputs on pin 5; fan-out: pins 0,3,7 carry function 2
      for (int i = 0; i < NI; i++) bus_write(i, 4'd5, "R4 write");
      bus_write(NI + 0, 4'd2, "R4 write");
      bus_write(NI + 3, 4'd2, "R4 write");
      bus_write(NI + 7, 4'd2, "R4 write");
      pin_in = 8'h20; periph_out = 5'b00010;
      check_routes("R4 fan");
      pin_in = 8'hDF; periph_out = 5'b11101;
      check_routes("R4 fan inverse");

      // R2 out-of-range select, R3 undefined and zero codes
      bus_write(1, 4'd9, "R2 write");
      bus_write(NI + 3, 4'd6, "R3 write");
      bus_write(NI + 7, 4'd15, "R3 write");
      bus_write(NI + 2, 4'd5, "R3 write");
      pin_in = '1; periph_out = '1;
      check_routes("R2 R3 boundary");

      // R5 locked writes, R9 out-of-map addresses
      cfg_lock = 1'b1;
      bus_write(0, 4'd3, "R5 locked write ack");
      bus_write(NI + 2, 4'd1, "R5 locked write ack");
      bus_read(0, "R5 value kept");
      bus_read(NI + 2, "R5 value kept");
      check_routes("R5 routing kept");
      cfg_lock = 1'b0;
      bus_write(NR, 4'd7, "R9 out-of-map write");
      bus_read(NR, "R9 out-of-map read zero");
      bus_read(15, "R9 top address read zero");
      #1;
      chk(mismatch_req === 1'b0, "R8 writes keep shadow", 32'(mismatch_req), 0);

      // Random mix
      for (int it = 0; it < 60; it++) begin
         cfg_lock = ($urandom_range(3) == 0);
         bus_write($urandom_range(15), RW'($urandom), "R6 random write ack");
         cfg_lock = ($urandom_range(1) == 0);
         bus_read($urandom_range(NR - 1), "R6 random readback");
         pin_in = NP'($urandom); periph_out = NO'($urandom);
         check_routes("R2 R3 random");
         chk(mismatch_req === 1'b0, "R8 no mismatch on writes", 32'(mismatch_req), 0);
      end
      cfg_lock = 1'b0;

      // R7 corrupt one live bit, R8 repair by rewrite
      @(negedge clk);
      force i_pin_xbar.u_bank.live_q = packed_model() ^ {{(NR*RW-1){1'b0}}, 1'b1};
      #1;
      release i_pin_xbar.u_bank.live_q;
      @(negedge clk);
      chk(mismatch_req === 1'b1, "R7 mismatch raised", 32'(mismatch_req), 1);
      @(negedge clk);
      chk(mismatch_req === 1'b1, "R7 mismatch held", 32'(mismatch_req), 1);
      bus_write(0, model[0], "R8 repair write");
      @(negedge clk);
      chk(mismatch_req === 1'b0, "R8 mismatch cleared", 32'(mismatch_req), 0);
      bus_read(0, "R8 repaired value");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule